// File: doc/BRIEF.md
# Split Isochronous Micro-frame Sequencer

This block paces one full-speed isochronous endpoint that sits behind a high-speed hub. It walks the eight host micro-frames of every host frame and decides, for each one, whether the host should send a start-split, a complete-split or nothing. At the first micro-frame tick of a new frame it latches that frame's schedule: a direction bit and two 8-bit masks indexed by hub micro-frame. Hub micro-frames run one slot behind the host. A start-split for hub micro-frame i goes out in host micro-frame i+1. A complete-split for hub micro-frame i is collected one slot after that, in host micro-frame i+2.

The mask layout matters for IN endpoints. A complete-split listed at hub micro-frame 6 or 7 lands in micro-frame 0 or 1 of the following host frame. The sequencer carries those pending complete-splits across the boundary and issues them at the start of the next frame. While it does so it raises a flag that tells the host to keep using the data buffer of the earlier frame's schedule. This means an IN transaction that spans two frame-list slots still uses a single data pointer. A schedule that breaks the direction rules is rejected: the block raises an error flag for that frame and issues none of that frame's own splits.

The controller is a three-state machine:
- IDLE: after reset, before the first tick.
- FRAME: counting host micro-frames 0 to 7.
- STALL: all eight micro-frames of the current frame are used and the frame number has not yet changed.

Its transitions are:
- IDLE to FRAME on the first tick.
- FRAME to FRAME on a tick that brings a new frame number, and also on a tick that advances the index.
- FRAME to STALL on a tick at micro-frame 7 with an unchanged frame number.
- STALL to FRAME on a tick with a new frame number.

Top module: `split_iso_sequencer`

## Requirements
- R1: A synchronous active-high reset drives the host micro-frame index to 0, both issue strobes low, the back-pointer flag low and the error flag low. It also drops any pending wrapped complete-splits, so the first frame after reset issues nothing in micro-frames 0 and 1. That first tick always opens a new frame, whatever the frame number.
- R2: For a legal schedule, start-split mask bit i (i = 0 to 6) gives a start-split strobe in host micro-frame i+1. For an IN schedule, complete-split mask bit i (i = 0 to 5) gives a complete-split strobe in host micro-frame i+2 of the same frame. No start-split is ever issued in host micro-frame 0.
- R3: For an OUT schedule (direction bit 0), any nonzero complete-split mask is illegal, and so is start-split mask bit 7, because that split would spill into the next frame.
- R4: For an IN schedule (direction bit 1) with any mask bit set, the schedule is illegal in any of these cases:
  - the start-split mask does not have exactly one bit set;
  - the complete-split mask is zero;
  - start-split bit 7 is set;
  - any complete-split bit sits below the start-split bit.
- R5: In a legal IN schedule, complete-split bits 6 and 7 are issued as complete-split strobes in micro-frames 0 and 1 of the next host frame.
- R6: The back-pointer flag is high from the next frame's micro-frame 0 up to and including the micro-frame of its last wrapped complete-split. It is low in every other micro-frame, including the whole of any frame with no wrapped complete-splits.
- R7: Each strobe is a one-clock pulse in the cycle after a micro-frame tick, and at most one strobe is high at a time.
- R8: A new schedule whose start-split bit 0 collides with a wrapped complete-split due in micro-frame 1 is illegal. The wrapped complete-splits from the previous frame are still issued.
- R9: A tick whose frame number differs from the latched one opens a new frame at micro-frame 0. Later ticks advance the index up to 7. Ticks beyond that, with no frame-number change, issue nothing, drop the back-pointer flag and leave the index at 7. Between ticks the index, error flag and back-pointer flag are stable.
- R10: A schedule with both masks zero is legal and issues nothing of its own.
- R11: The error flag reflects the schedule latched for the current frame. An illegal frame issues none of its own strobes and carries nothing forward. The flag clears at the next frame that latches a legal schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uf_tick | input | 1 | One-cycle pulse at the start of each host micro-frame |
| frame_num | input | FN_W | Current host frame number |
| dir_in | input | 1 | Schedule direction: 1 = IN, 0 = OUT |
| ss_mask | input | 8 | Start-split mask indexed by hub micro-frame |
| cs_mask | input | 8 | Complete-split mask indexed by hub micro-frame |
| ss_issue | output | 1 | Issue a start-split in this micro-frame |
| cs_issue | output | 1 | Issue a complete-split in this micro-frame |
| use_back_ptr | output | 1 | Take the data buffer from the previous frame's schedule |
| sched_err | output | 1 | The schedule latched for this frame is illegal |
| host_uframe | output | 3 | Current host micro-frame index |

## Verification
The assertions take three things for granted about the inputs. `uf_tick` is a single-cycle pulse. The frame number changes only between ticks. The schedule inputs are stable in the tick cycle that opens a frame. The stimulus follows these rules: it changes frame number and masks at the falling edge before a tick, and it leaves an idle cycle between ticks. It also scrambles the masks after the opening tick, which shows that only the latched schedule drives the strobes.

// File: rtl/split_seq_pkg.sv
package split_seq_pkg;

    localparam int UF_PER_FRAME = 8;
    localparam int UF_IDX_W     = $clog2(UF_PER_FRAME);
    // Complete-splits trail their hub micro-frame by this many host slots,
    // which is also the number of slots that can spill into the next frame.
    localparam int CS_LAG       = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_STALL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                    is_in;
        logic [UF_PER_FRAME-1:0] ss;
        logic [UF_PER_FRAME-1:0] cs;
    } split_desc_t;

endpackage

// File: rtl/split_rule_check.sv
module split_rule_check
    import split_seq_pkg::*;
(
    input  split_desc_t       desc,
    input  logic              late_carry,
    output logic              illegal,
    output logic [CS_LAG-1:0] spill
);

    localparam int LAST = UF_PER_FRAME - 1;

    logic [UF_PER_FRAME-1:0] start_above;
    logic [UF_IDX_W:0]       n_start;
    logic                    active;
    logic                    collide;
    logic                    early_cs;
    logic                    out_bad;
    logic                    in_bad;

    // start_above[k]: some start-split bit sits strictly above bit k
    for (genvar k = 0; k < UF_PER_FRAME; k++) begin : g_above
        if (k == LAST) begin : g_top
            assign start_above[k] = 1'b0;
        end else begin : g_mid
            assign start_above[k] = |desc.ss[LAST:k+1];
        end
    end

    always_comb begin
        n_start = '0;
        for (int i = 0; i < UF_PER_FRAME; i++) begin
            n_start = n_start + {{UF_IDX_W{1'b0}}, desc.ss[i]};
        end
    end

    assign active   = (|desc.ss) | (|desc.cs);
    assign collide  = desc.ss[0] & late_carry;
    assign early_cs = |(desc.cs & start_above);
    assign out_bad  = (|desc.cs) | desc.ss[LAST];
    assign in_bad   = (desc.cs == '0)
                    | (n_start != (UF_IDX_W+1)'(1))
                    | desc.ss[LAST]
                    | early_cs;

    assign illegal = active & (collide | (desc.is_in ? in_bad : out_bad));
    assign spill   = (illegal | ~desc.is_in) ? '0
                   : desc.cs[UF_PER_FRAME-CS_LAG +: CS_LAG];

endmodule

// File: rtl/split_slot_decode.sv
module split_slot_decode
    import split_seq_pkg::*;
(
    input  split_desc_t         desc,
    input  logic [CS_LAG-1:0]   carry,
    input  logic [UF_IDX_W-1:0] slot,
    output logic                want_ss,
    output logic                want_cs,
    output logic                want_bp
);

    logic [UF_PER_FRAME-1:0] ss_at;
    logic [UF_PER_FRAME-1:0] cs_at;
    logic [UF_PER_FRAME-1:0] bp_at;
    logic                    decode_unused;

    for (genvar s = 0; s < UF_PER_FRAME; s++) begin : g_slot
        if (s == 0) begin : g_first
            assign ss_at[s] = 1'b0;
        end else begin : g_rest
            assign ss_at[s] = desc.ss[s-1];
        end
        if (s < CS_LAG) begin : g_wrapped
            assign cs_at[s] = carry[s];
            assign bp_at[s] = |carry[CS_LAG-1:s];
        end else begin : g_own
            assign cs_at[s] = desc.is_in & desc.cs[s-CS_LAG];
            assign bp_at[s] = 1'b0;
        end
    end

    // Spilled bits are handled through carry, not through this frame's slots.
    assign decode_unused = ^{desc.ss[UF_PER_FRAME-1],
                             desc.cs[UF_PER_FRAME-1 -: CS_LAG]};

    assign want_ss = ss_at[slot];
    assign want_cs = cs_at[slot];
    assign want_bp = bp_at[slot];

endmodule

// File: rtl/split_iso_sequencer.sv
module split_iso_sequencer
    import split_seq_pkg::*;
#(
    parameter int FN_W = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    uf_tick,
    input  logic [FN_W-1:0]         frame_num,
    input  logic                    dir_in,
    input  logic [UF_PER_FRAME-1:0] ss_mask,
    input  logic [UF_PER_FRAME-1:0] cs_mask,
    output logic                    ss_issue,
    output logic                    cs_issue,
    output logic                    use_back_ptr,
    output logic                    sched_err,
    output logic [UF_IDX_W-1:0]     host_uframe
);

    localparam logic [UF_IDX_W-1:0] LAST_UF = UF_IDX_W'(UF_PER_FRAME - 1);

    seq_state_e          st_q, st_d;
    logic [UF_IDX_W-1:0] slot_q, slot_d;
    logic [FN_W-1:0]     fn_q;
    split_desc_t         desc_q, desc_in;
    logic [CS_LAG-1:0]   wrap_q;
    logic [CS_LAG-1:0]   carry_q;
    logic [CS_LAG-1:0]   carry_eval;
    logic                new_frame;
    logic                tick_live;
    logic                illegal;
    logic [CS_LAG-1:0]   spill;
    logic                want_ss, want_cs, want_bp;

    assign desc_in   = '{is_in: dir_in, ss: ss_mask, cs: cs_mask};
    assign new_frame = uf_tick & ((st_q == ST_IDLE) | (frame_num != fn_q));
    assign tick_live = new_frame
                     | (uf_tick & (st_q == ST_FRAME) & (slot_q != LAST_UF));

    split_rule_check u_rules (
        .desc       (desc_in),
        .late_carry (wrap_q[CS_LAG-1]),
        .illegal    (illegal),
        .spill      (spill)
    );

    assign carry_eval = new_frame ? wrap_q : carry_q;

    split_slot_decode u_decode (
        .desc    (desc_q),
        .carry   (carry_eval),
        .slot    (slot_d),
        .want_ss (want_ss),
        .want_cs (want_cs),
        .want_bp (want_bp)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (new_frame) st_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (new_frame)                          st_d = ST_FRAME;
                else if (uf_tick && slot_q == LAST_UF)  st_d = ST_STALL;
            end
            ST_STALL: begin
                if (new_frame) st_d = ST_FRAME;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (new_frame)      slot_d = '0;
        else if (tick_live) slot_d = slot_q + 1'b1;
        else                slot_d = slot_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // frame context
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            fn_q    <= '0;
            desc_q  <= '0;
            wrap_q  <= '0;
            carry_q <= '0;
        end else begin
            slot_q <= slot_d;
            if (new_frame) begin
                fn_q    <= frame_num;
                desc_q  <= illegal ? '0 : desc_in;
                wrap_q  <= spill;
                carry_q <= wrap_q;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ss_issue     <= 1'b0;
            cs_issue     <= 1'b0;
            use_back_ptr <= 1'b0;
            sched_err    <= 1'b0;
        end else begin
            ss_issue <= tick_live & want_ss;
            cs_issue <= tick_live & want_cs;
            if (uf_tick)   use_back_ptr <= tick_live & want_bp;
            if (new_frame) sched_err    <= illegal;
        end
    end

    assign host_uframe = slot_q;

endmodule

// File: rtl/split_iso_sequencer_chk.sv
module split_iso_sequencer_chk
    import split_seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                uf_tick,
    input logic                ss_issue,
    input logic                cs_issue,
    input logic                use_back_ptr,
    input logic                sched_err,
    input logic [UF_IDX_W-1:0] host_uframe
);

    logic armed;

    always_ff @(posedge clk) armed <= ~rst;

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        $onehot0({ss_issue, cs_issue}));

    assert_strobe_after_tick_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        (ss_issue || cs_issue) |-> $past(uf_tick));

    assert_bp_window_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        use_back_ptr |-> (host_uframe <= UF_IDX_W'(CS_LAG - 1)));

    assert_no_start_uf0_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        ss_issue |-> (host_uframe != '0));

    assert_err_no_start_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        sched_err |-> !ss_issue);

    assert_err_no_own_cs_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (sched_err && host_uframe >= UF_IDX_W'(CS_LAG)) |-> !cs_issue);

    assert_steady_between_ticks_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(uf_tick) |-> ($stable(host_uframe) && $stable(sched_err) && $stable(use_back_ptr)));

endmodule

bind split_iso_sequencer split_iso_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .uf_tick      (uf_tick),
    .ss_issue     (ss_issue),
    .cs_issue     (cs_issue),
    .use_back_ptr (use_back_ptr),
    .sched_err    (sched_err),
    .host_uframe  (host_uframe)
);

// File: tb/split_iso_sequencer_test.sv
module split_iso_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uf_tick = 1'b0;
    logic [10:0] frame_num = '0;
    logic        dir_in = 1'b0;
    logic [7:0]  ss_mask = '0;
    logic [7:0]  cs_mask = '0;
    logic        ss_issue, cs_issue, use_back_ptr, sched_err;
    logic [2:0]  host_uframe;

    int          nvec = 0;
    int          nbad = 0;
    bit          finished = 0;
    logic [1:0]  m_carry = '0;
    logic [10:0] fn_cnt = '0;

    always #10 clk = ~clk;

    split_iso_sequencer uut (
        .clk          (clk),
        .rst          (rst),
        .uf_tick      (uf_tick),
        .frame_num    (frame_num),
        .dir_in       (dir_in),
        .ss_mask      (ss_mask),
        .cs_mask      (cs_mask),
        .ss_issue     (ss_issue),
        .cs_issue     (cs_issue),
        .use_back_ptr (use_back_ptr),
        .sched_err    (sched_err),
        .host_uframe  (host_uframe)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    // legality from the requirements: R3, R4, R8, R10
    function automatic bit bad_sched(input bit is_in, input logic [7:0] s,
                                     input logic [7:0] c, input bit late);
        int starts = 0;
        int lowest = 8;
        if (s == 8'h00 && c == 8'h00) return 1'b0;
        if (s[0] && late) return 1'b1;
        if (!is_in) return (c != 8'h00) || s[7];
        for (int i = 7; i >= 0; i--) if (s[i]) begin starts++; lowest = i; end
        if (c == 8'h00 || starts != 1 || s[7]) return 1'b1;
        for (int i = 0; i < lowest; i++) if (c[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        uf_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_carry = '0;
        chk("R1", "uframe", host_uframe, 0);
        chk("R1", "ss", ss_issue, 0);
        chk("R1", "cs", cs_issue, 0);
        chk("R1", "bp", use_back_ptr, 0);
        chk("R1", "err", sched_err, 0);
    endtask

    task automatic run_frame(input string etag, input bit is_in, input logic [7:0] s,
                             input logic [7:0] c, input int nticks);
        bit         e_err;
        logic [1:0] cin;
        int         eu, ess, ecs, ebp;
        cin   = m_carry;
        e_err = bad_sched(is_in, s, c, cin[1]);
        fn_cnt = fn_cnt + 11'd1;
        @(negedge clk);
        frame_num = fn_cnt;
        dir_in    = is_in;
        ss_mask   = s;
        cs_mask   = c;
        for (int t = 0; t < nticks; t++) begin
            uf_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            uf_tick = 1'b0;
            if (t == 0) begin
                dir_in  = ~is_in;
                ss_mask = 8'($urandom);
                cs_mask = 8'($urandom);
            end
            if (t >= 8) begin
                eu = 7; ess = 0; ecs = 0; ebp = 0;
            end else begin
                eu  = t;
                ess = (!e_err && t >= 1) ? int'(s[t-1]) : 0;
                if (t < 2) ecs = int'(cin[t]);
                else       ecs = (!e_err && is_in) ? int'(c[t-2]) : 0;
                if (t == 0)      ebp = int'(|cin);
                else if (t == 1) ebp = int'(cin[1]);
                else             ebp = 0;
            end
            chk("R9", "uframe", host_uframe, eu);
            chk("R2", "start-split", ss_issue, ess);
            chk(t < 2 ? "R5" : "R2", "complete-split", cs_issue, ecs);
            chk("R6", "back-pointer", use_back_ptr, ebp);
            chk(etag, "error", sched_err, int'(e_err));
            @(posedge clk);
            @(negedge clk);
            chk("R7", "pulse width", int'(ss_issue | cs_issue), 0);
        end
        m_carry = (!e_err && is_in) ? {c[7], c[6]} : 2'b00;
    endtask

    initial begin
        #(20 * 200000);
        nbad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(negedge clk);
        do_reset();

        // R2: OUT start-splits at alternating micro-frames
        run_frame("R3", 1'b0, 8'h55, 8'h00, 8);
        // R5/R6: IN wrapping one complete-split into uf0
        run_frame("R4", 1'b1, 8'h04, 8'h78, 8);
        run_frame("R3", 1'b0, 8'h02, 8'h00, 8);
        // R5/R6: IN wrapping two complete-splits
        run_frame("R4", 1'b1, 8'h20, 8'hC0, 8);
        // R8: collision of new start at uf1 with wrapped split
        run_frame("R8", 1'b0, 8'h01, 8'h00, 8);
        // R3: OUT with complete-splits, OUT spilling start
        run_frame("R3", 1'b0, 8'h10, 8'h04, 8);
        run_frame("R3", 1'b0, 8'h80, 8'h00, 8);
        // R11: legal frame clears error
        run_frame("R11", 1'b0, 8'h08, 8'h00, 8);
        // R4: IN rule breaks
        run_frame("R4", 1'b1, 8'h03, 8'h0C, 8);
        run_frame("R4", 1'b1, 8'h02, 8'h00, 8);
        run_frame("R4", 1'b1, 8'h08, 8'h14, 8);
        run_frame("R4", 1'b1, 8'h00, 8'h30, 8);
        run_frame("R4", 1'b1, 8'h80, 8'h80, 8);
        // R10: empty schedule
        run_frame("R10", 1'b1, 8'h00, 8'h00, 8);
        // R9: extra ticks without frame change
        run_frame("R9", 1'b1, 8'h01, 8'h43, 11);
        // R9: short frame cut by a new number
        run_frame("R4", 1'b1, 8'h10, 8'hF0, 5);
        run_frame("R9", 1'b0, 8'h22, 8'h00, 8);
        // R1: reset drops a pending wrap; same frame number still opens a frame
        run_frame("R4", 1'b1, 8'h40, 8'hC0, 8);
        do_reset();
        fn_cnt = fn_cnt - 11'd1;
        run_frame("R1", 1'b0, 8'h01, 8'h00, 8);

        // constrained random mix
        for (int f = 0; f < 300; f++) begin
            int         mode;
            int         j;
            bit         is_in;
            logic [7:0] s, c;
            mode = $urandom_range(0, 3);
            case (mode)
                0: begin is_in = 0; s = 8'($urandom) & 8'h7F; c = 8'h00; end
                1: begin
                    is_in = 1;
                    j = $urandom_range(0, 6);
                    s = 8'(1 << j);
                    c = 8'($urandom) & ~8'((1 << j) - 1);
                    if (c == 8'h00) c = s;
                end
                2: begin is_in = 1'($urandom); s = 8'($urandom); c = 8'($urandom); end
                default: begin is_in = 1'($urandom); s = 8'h00; c = 8'h00; end
            endcase
            run_frame(is_in ? "R4" : "R3", is_in, s, c, 8);
        end
        summary();
    end

endmodule